// File: doc/BRIEF.md
# Autoranging Range Selector

This block picks the measuring range of a dual-slope meter. It holds a small range position that moves one step at a time. Each time a fresh conversion result is presented with a load strobe, the position goes up if the reading is too large and down if it is too small. The position is then decoded into one-hot select lines that drive the range relays and the decimal point directly.

Three control inputs change how it behaves. The first picks one of two decode groups, either voltage or resistance. The second pins the position at its top value for as long as it is held. The third sends the raw position bits to the outputs so that the ranges can be decoded outside the block. In this raw mode the position may also use all of its values. Otherwise it stays in a lower window, and if it starts above that window it can only step down into it.

Top module: `autorange_top`

## Requirements
- R1: While reset is held, and on leaving reset, the position is 0. With both mode inputs low, `rangeSel` reads 5'b00001.
- R2: When `loadStrobe` is high and the result is above 5500, the position rises by exactly one at the next clock edge. A result of exactly 5500 leaves it unchanged.
- R3: When `loadStrobe` is high and the result is below 500, the position falls by exactly one. A result of exactly 500 leaves it unchanged.
- R4: When `overRange` is high together with `loadStrobe`, the block steps up whatever the digits are.
- R5: A cycle with `loadStrobe` low leaves the position unchanged, whatever the result inputs carry.
- R6: A step down at position 0 leaves the position at 0.
- R7: With `rawMode` low, a step up is blocked at position 4 and at any position above it. A position above 4 can only step down.
- R8: While `forceTop` is high, the position becomes 7 at the next edge and stays there. Results and strobes are ignored.
- R9: With `rawMode` high, `rangeSel[2:0]` carries the position in binary and `rangeSel[4:3]` is 0. The position may rise to 7 and stays at 7 when stepped up again.
- R10: With `rawMode` and `selOhms` low, exactly one output is high. Positions 0 to 3 drive bits 0 to 3, and positions above 3 drive bit 3.
- R11: With `selOhms` high and `rawMode` low, positions 0 to 3 drive bits 1 to 4, and positions above 3 drive bit 4.
- R12: `resultBcd` is read as four BCD digits, with the thousands digit in bits 15:12 and the units digit in bits 3:0. It is compared by its decimal value, so 16'h5501 steps up and 16'h0499 steps down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadStrobe | input | 1 | A new conversion result is valid this cycle |
| resultBcd | input | 16 | Conversion result as four BCD digits |
| overRange | input | 1 | The conversion overflowed its count |
| selOhms | input | 1 | Selects the resistance decode group |
| forceTop | input | 1 | Holds the position at its maximum |
| rawMode | input | 1 | Sends the raw position to the outputs and opens the full window |
| rangeSel | output | 5 | Range select lines |

## Verification
The position register is the only state, and `rangeSel` decodes it without a register in between. A wrong position therefore shows on the outputs in the cycle right after the faulty edge. In both internal decode groups, positions 3 and 4 give the same output, so raw mode is used to show the exact position when a window or saturation limit is checked. The threshold corners 499/500 and 5500/5501 are driven, along with the overrange flag on a small reading, a lapse of force-top above the window, and saturation at both ends.

// File: rtl/autorange_pkg.sv
package autorange_pkg;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic forceTop;
  } rangeCmd_t;

  function automatic int unsigned pow10(input int unsigned e);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < e; i++) r = r * 10;
    return r;
  endfunction

endpackage

// File: rtl/autorange_ctrl.sv
module autorange_ctrl
  import autorange_pkg::*;
#(
  parameter int DIGITS   = 4,
  parameter int UP_LIM   = 5500,
  parameter int DOWN_LIM = 500
) (
  input  logic                  loadStrobe,
  input  logic [DIGITS*4-1:0]   resultBcd,
  input  logic                  overRange,
  input  logic                  forceTop,
  output rangeCmd_t             cmd
);
  localparam int VAL_W = $clog2(pow10(DIGITS));

  logic [VAL_W-1:0] partial [DIGITS+1];
  assign partial[0] = '0;

  genvar d;
  generate
    for (d = 0; d < DIGITS; d++) begin : g_digit
      localparam logic [VAL_W-1:0] WEIGHT = VAL_W'(pow10(d));
      logic [VAL_W-1:0] digitVal;
      assign digitVal     = VAL_W'(resultBcd[d*4 +: 4]);
      assign partial[d+1] = partial[d] + digitVal * WEIGHT;
    end
  endgenerate

  logic [VAL_W-1:0] value;
  logic             isHigh;
  logic             isLow;

  assign value  = partial[DIGITS];
  assign isHigh = overRange || (value > VAL_W'(UP_LIM));
  assign isLow  = value < VAL_W'(DOWN_LIM);

  always_comb begin
    cmd.forceTop = forceTop;
    cmd.stepUp   = loadStrobe && isHigh;
    cmd.stepDown = loadStrobe && !isHigh && isLow;
  end

endmodule

// File: rtl/autorange_dp.sv
module autorange_dp
  import autorange_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int ZONE_TOP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  rangeCmd_t        cmd,
  input  logic             rawMode,
  output logic [CNT_W-1:0] pos
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] ZONE_LIM = CNT_W'(ZONE_TOP);

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] posNext;

  assign limit = rawMode ? CNT_MAX : ZONE_LIM;

  always_comb begin
    posNext = pos;
    if (cmd.forceTop)                     posNext = CNT_MAX;
    else if (cmd.stepUp && pos < limit)   posNext = pos + 1'b1;
    else if (cmd.stepDown && pos != '0)   posNext = pos - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pos <= '0;
    else       pos <= posNext;
  end

  assert_force_top_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.forceTop |=> (pos == CNT_MAX));

  assert_zone_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!rawMode && !cmd.forceTop && pos <= ZONE_LIM) |=> (pos <= ZONE_LIM));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.stepUp && !cmd.stepDown && !cmd.forceTop) |=> $stable(pos));

  assert_floor_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pos == '0 && !cmd.forceTop) |=> (pos <= CNT_W'(1)));

  assert_ceiling_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pos == CNT_MAX) |=> (pos >= CNT_MAX - 1'b1));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.forceTop |=> (pos == $past(pos) || pos == $past(pos) + 1'b1 ||
                       pos == $past(pos) - 1'b1));

endmodule

// File: rtl/range_decode.sv
module range_decode #(
  parameter int CNT_W      = 3,
  parameter int NUM_RANGES = 4,
  parameter int NUM_OUT    = NUM_RANGES + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   pos,
  input  logic               selOhms,
  input  logic               rawMode,
  output logic [NUM_OUT-1:0] rangeSel
);
  localparam int IDX_W = $clog2(NUM_OUT) + 1;
  localparam logic [CNT_W-1:0] TOP_RANGE = CNT_W'(NUM_RANGES - 1);

  logic [CNT_W-1:0] clipped;
  logic [IDX_W-1:0] idx;

  assign clipped = (pos > TOP_RANGE) ? TOP_RANGE : pos;
  assign idx     = IDX_W'(clipped) + IDX_W'(selOhms);

  genvar j;
  generate
    for (j = 0; j < NUM_OUT; j++) begin : g_out
      logic rawBit;
      if (j < CNT_W) begin : g_raw
        assign rawBit = pos[j];
      end else begin : g_pad
        assign rawBit = 1'b0;
      end
      assign rangeSel[j] = rawMode ? rawBit : (idx == IDX_W'(j));
    end
  endgenerate

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rawMode |-> ($countones(rangeSel) == 1));

  assert_ohms_floor_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!rawMode && selOhms) |-> !rangeSel[0]);

endmodule

// File: rtl/autorange_top.sv
module autorange_top
  import autorange_pkg::*;
#(
  parameter int DIGITS     = 4,
  parameter int CNT_W      = 3,
  parameter int ZONE_TOP   = 4,
  parameter int NUM_RANGES = 4,
  parameter int UP_LIM     = 5500,
  parameter int DOWN_LIM   = 500,
  parameter int NUM_OUT    = NUM_RANGES + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadStrobe,
  input  logic [DIGITS*4-1:0] resultBcd,
  input  logic                overRange,
  input  logic                selOhms,
  input  logic                forceTop,
  input  logic                rawMode,
  output logic [NUM_OUT-1:0]  rangeSel
);
  rangeCmd_t        cmd;
  logic [CNT_W-1:0] pos;

  autorange_ctrl #(.DIGITS(DIGITS), .UP_LIM(UP_LIM), .DOWN_LIM(DOWN_LIM)) u_ctrl (
    .loadStrobe(loadStrobe), .resultBcd(resultBcd), .overRange(overRange),
    .forceTop(forceTop), .cmd(cmd)
  );

  autorange_dp #(.CNT_W(CNT_W), .ZONE_TOP(ZONE_TOP)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rawMode(rawMode), .pos(pos)
  );

  range_decode #(.CNT_W(CNT_W), .NUM_RANGES(NUM_RANGES), .NUM_OUT(NUM_OUT)) u_dec (
    .clk(clk), .rstN(rstN), .pos(pos), .selOhms(selOhms), .rawMode(rawMode),
    .rangeSel(rangeSel)
  );

endmodule

// File: tb/autorange_top_tb.sv
module autorange_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStrobe = 1'b0;
  logic [15:0] resultBcd = 16'h0000;
  logic        overRange = 1'b0;
  logic        selOhms = 1'b0;
  logic        forceTop = 1'b0;
  logic        rawMode = 1'b0;
  logic [4:0]  rangeSel;

  int testsRun = 0;
  int testsFailed = 0;
  int refPos = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  autorange_top u_dut (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .resultBcd(resultBcd),
    .overRange(overRange), .selOhms(selOhms), .forceTop(forceTop),
    .rawMode(rawMode), .rangeSel(rangeSel)
  );

  function automatic int bcdValue(input logic [15:0] b);
    return b[15:12] * 1000 + b[11:8] * 100 + b[7:4] * 10 + b[3:0];
  endfunction

  function automatic logic [4:0] expectSel(input int p, input bit ohms, input bit raw);
    int k;
    if (raw) return 5'(p);
    k = (p > 3) ? 3 : p;
    if (ohms) k = k + 1;
    return 5'(1 << k);
  endfunction

  task automatic check(input string req);
    logic [4:0] exp;
    exp = expectSel(refPos, selOhms, rawMode);
    testsRun++;
    if (rangeSel !== exp) begin
      testsFailed++;
      $display("FAIL %s: rangeSel=%b expected=%b (pos %0d)", req, rangeSel, exp, refPos);
    end
  endtask

  // one clock: apply inputs, advance the model at the edge, compare after it
  task automatic step(input bit stb, input logic [15:0] bcd, input bit ovr,
                      input bit ohms, input bit frc, input bit raw, input string req);
    int v;
    int lim;
    bit up;
    bit dn;
    loadStrobe = stb; resultBcd = bcd; overRange = ovr;
    selOhms = ohms; forceTop = frc; rawMode = raw;
    @(posedge clk);
    v = bcdValue(bcd);
    up = stb && (ovr || v > 5500);
    dn = stb && !up && v < 500;
    lim = raw ? 7 : 4;
    if (frc) refPos = 7;
    else if (up && refPos < lim) refPos++;
    else if (dn && refPos > 0) refPos--;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    step(1, 16'h5501, 0, 0, 0, 0, "R2 R12 5501 up");
    step(1, 16'h5500, 0, 0, 0, 0, "R2 5500 hold");
    step(0, 16'h9999, 0, 0, 0, 0, "R5 no strobe high");
    step(0, 16'h0000, 1, 0, 0, 0, "R5 no strobe ovr");
    step(1, 16'h0100, 1, 0, 0, 0, "R4 overrange up");
    step(1, 16'h6000, 0, 0, 0, 0, "R10 pos3");
    step(1, 16'h5999, 0, 0, 0, 0, "R10 pos4 top bit");
    step(1, 16'h9999, 0, 0, 0, 0, "R7 blocked at 4");
    step(0, 16'h0000, 0, 0, 0, 1, "R7 raw view pos4");
    step(0, 16'h0000, 0, 1, 0, 0, "R11 ohms pos4");
    step(1, 16'h0499, 0, 1, 0, 0, "R3 R12 0499 down");
    step(1, 16'h0500, 0, 1, 0, 0, "R3 0500 hold");
    step(1, 16'h0000, 0, 1, 0, 0, "R11 ohms pos2");
    step(1, 16'h0000, 0, 1, 0, 0, "R11 ohms pos1");
    step(1, 16'h0000, 0, 1, 0, 0, "R11 ohms pos0");
    step(1, 16'h0000, 0, 0, 0, 0, "R6 floor");
    step(1, 16'h0000, 0, 0, 1, 0, "R8 force with down");
    step(1, 16'h0000, 0, 0, 1, 1, "R8 force raw view");
    step(0, 16'h0000, 0, 0, 1, 1, "R8 held");
    step(1, 16'h9999, 0, 0, 0, 1, "R9 ceiling raw");
    step(1, 16'h9999, 0, 0, 0, 0, "R7 above zone no up");
    step(0, 16'h0000, 0, 0, 0, 1, "R7 raw view pos7");
    step(1, 16'h0001, 0, 0, 0, 0, "R7 above zone down");
    step(0, 16'h0000, 0, 0, 0, 1, "R7 raw view pos6");
    for (int i = 0; i < 7; i++) step(1, 16'h0050, 0, 0, 0, 1, "R9 raw down");
    for (int i = 0; i < 9; i++) step(1, 16'h8000, 0, 0, 0, 1, "R9 raw up");
    step(1, 16'h0499, 1, 0, 0, 1, "R4 ovr beats low");
    step(1, 16'h0200, 0, 0, 0, 1, "R9 raw down from 7");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule